// File: doc/BRIEF.md
# Neighbor-Aware Zero-Suppression Write Gate

This block sits between a bank of eight ADC channels and the sample store of one readout section. On every sample strobe it receives one 12-bit sample per channel and decides which samples are worth keeping. A channel whose sample reaches a programmable threshold triggers a capture window. The window opens on that channel and on the channels on either side of it. It is stretched backwards and forwards in time by a fixed number of samples, so that the faint rising and falling edges of a pulse reach the store along with its peak.

The two outermost channels also trade triggers with the neighboring sections. Each section reports its own edge-channel hits to the section beside it, and a trigger arriving from a neighboring section widens the window of the adjacent edge channel in the same way a local hit does. Each channel has a short delay line, so the stored data stream is the delayed sample paired with its widened write-enable. The enable is a single-cycle pulse in the clock after each strobe.

Top module: `zs_neighbor_gate`

## Requirements
- R1: A channel counts as hit on a strobe when its sample, read as unsigned, is greater than or equal to `thresh`. A sample of `thresh - 1` is not a hit.
- R2: A hit on channel i gates channels i-1, i and i+1 on that strobe.
- R3: `trig_in_lo` asserted during a strobe gates channel 0, and `trig_in_hi` gates channel 7, exactly as a hit on a channel just beyond the edge would.
- R4: `trig_out_lo` is high, in the same cycle, exactly while a strobe is present and channel 0 is hit. `trig_out_hi` does the same for channel 7. Neither output depends on the trigger inputs.
- R5: The sample taken on strobe k of a channel is stored if and only if that channel is gated on some strobe from k-2 to k+2.
- R6: `wr_en` bits can be high only in the cycle right after a strobe. At that point `wr_data` lane c carries channel c's sample from two strobes earlier. The lane for channel c is bits [12c+11:12c].
- R7: Gates that fall within two windows of each other extend one continuous run of enables, with no gap, because every new gate restarts the trailing count.
- R8: While `rst_n` is low, all enables are low. After reset, the first two strobes store nothing, because there is no earlier sample to pair with them. Afterwards, earlier gates and samples have no effect.
- R9: Cycles without a strobe do not move the delay lines or the trailing windows. Only strobes count as time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low acquisition reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample set |
| smp_data | input | 96 | Eight 12-bit samples, channel c in bits [12c+11:12c] |
| thresh | input | 12 | Hit threshold (unsigned) |
| trig_in_lo | input | 1 | Trigger from the section below channel 0 |
| trig_in_hi | input | 1 | Trigger from the section above channel 7 |
| trig_out_lo | output | 1 | Channel 0 hit, sent to the section below |
| trig_out_hi | output | 1 | Channel 7 hit, sent to the section above |
| wr_en | output | 8 | Per-channel store enable, one bit per channel |
| wr_data | output | 96 | Delayed samples paired with `wr_en` |

## Verification
A wrong trailing count appears as an enable pulse that ends too early or too late. This shows on the strobe that follows the window's last gate, at most four strobes after it. A corrupted delay line appears as wrong `wr_data` on the first enabled pulse, two strobes after the sample entered. A wrong neighbor spread, or wrong handling of the edge trigger inputs, shows in the pulse right after the strobe that caused it. The reference model rebuilds the gating from the samples and compares every enable bit and every enabled data lane each clock. Because of this, any of these faults surfaces within a few strobes.

// File: rtl/zs_pkg.sv
// Package: shared defaults for the zero-suppression gate.
// Assumes: all modules of the block take these as parameter defaults.
package zs_pkg;
    parameter int ZS_NUM_CH = 8;   // channels per section
    parameter int ZS_SMP_W  = 12;  // ADC sample width
    parameter int ZS_PRE    = 2;   // samples kept ahead of a gate
    parameter int ZS_POST   = 2;   // samples kept after a gate
endpackage

// File: rtl/zs_hit_detect.sv
// Module: zs_hit_detect
// Compares every channel's sample with the threshold. Each hit is then
// spread onto the two adjacent channels. Triggers from the neighboring
// sections take the place of the missing channels beyond either edge.
// Assumes: all outputs are combinational and qualified by smp_valid.
module zs_hit_detect
    import zs_pkg::*;
#(
    parameter int NUM_CH = ZS_NUM_CH,
    parameter int SMP_W  = ZS_SMP_W
) (
    input  logic                    smp_valid,
    input  logic [NUM_CH*SMP_W-1:0] smp_data,
    input  logic [SMP_W-1:0]        thresh,
    input  logic                    trig_in_lo,
    input  logic                    trig_in_hi,
    output logic [NUM_CH-1:0]       hit,
    output logic [NUM_CH-1:0]       gate
);
    localparam int EXT_W = NUM_CH + 2;

    logic [EXT_W-1:0] ext_hit;

    // Threshold compare per channel, only meaningful on a strobe.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
        assign hit[ch] = smp_valid && (smp_data[ch*SMP_W +: SMP_W] >= thresh);
    end

    // Hit vector extended with the external edge triggers.
    assign ext_hit = {smp_valid & trig_in_hi, hit, smp_valid & trig_in_lo};

    // Three-wide neighbor spread.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_spread
        assign gate[ch] = ext_hit[ch] | ext_hit[ch+1] | ext_hit[ch+2];
    end
endmodule

// File: rtl/zs_chan_window.sv
// Module: zs_chan_window
// Widens one channel's gate in time. A delay line of PRE samples lets a
// gate reach backwards. A trailing counter, reloaded by every gate,
// reaches PRE+POST strobes forwards. The result is a one-cycle write
// pulse after each strobe, paired with the delayed sample.
// Assumes: filled is low until PRE strobes have entered since reset.
module zs_chan_window
    import zs_pkg::*;
#(
    parameter int SMP_W = ZS_SMP_W,
    parameter int PRE   = ZS_PRE,
    parameter int POST  = ZS_POST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             filled,
    input  logic             gate,
    input  logic [SMP_W-1:0] smp_in,
    output logic             wr_en_o,
    output logic [SMP_W-1:0] wr_data_o
);
    localparam int SPAN  = PRE + POST;
    localparam int CNT_W = $clog2(SPAN + 1);

    logic [SMP_W-1:0] dly [PRE];
    logic [CNT_W-1:0] cnt;

    // Delay line: shifts one place per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PRE; i++) dly[i] <= '0;
        end else if (smp_valid) begin
            dly[0] <= smp_in;
            for (int i = 1; i < PRE; i++) dly[i] <= dly[i-1];
        end
    end

    // Trailing counter: reloaded on a gate, counts down per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (smp_valid) begin
            if (gate)            cnt <= CNT_W'(SPAN);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
        end
    end

    // Output pulse and the delayed sample it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o   <= 1'b0;
            wr_data_o <= '0;
        end else if (smp_valid) begin
            wr_en_o   <= filled && (gate || (cnt != '0));
            wr_data_o <= dly[PRE-1];
        end else begin
            wr_en_o   <= 1'b0;
        end
    end

    // R9: idle cycles freeze the counter and the delay line.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(cnt) && $stable(dly[PRE-1])));

    // R2: a gate on a filled strobe always produces a write pulse.
    p_window_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && gate && filled) |=> wr_en_o);

    // R5: no gate and an expired count close the window.
    p_window_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !gate && cnt == '0) |=> !wr_en_o);
endmodule

// File: rtl/zs_neighbor_gate.sv
// Module: zs_neighbor_gate (top)
// Zero-suppression write gate for one section of channels. It finds
// threshold hits, spreads them to adjacent channels and across the
// section edges, and widens each channel's window by PRE samples
// before and POST samples after. It drives the edge trigger outputs.
// Assumes: one strobe carries one sample per channel. rst_n is the
// acquisition reset and is synchronous.
module zs_neighbor_gate
    import zs_pkg::*;
#(
    parameter int NUM_CH = ZS_NUM_CH,
    parameter int SMP_W  = ZS_SMP_W,
    parameter int PRE    = ZS_PRE,
    parameter int POST   = ZS_POST
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [NUM_CH*SMP_W-1:0] smp_data,
    input  logic [SMP_W-1:0]        thresh,
    input  logic                    trig_in_lo,
    input  logic                    trig_in_hi,
    output logic                    trig_out_lo,
    output logic                    trig_out_hi,
    output logic [NUM_CH-1:0]       wr_en,
    output logic [NUM_CH*SMP_W-1:0] wr_data
);
    localparam int FILL_W = $clog2(PRE + 1);

    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] gate;
    logic [FILL_W-1:0] fill_cnt;
    logic              filled;

    zs_hit_detect #(.NUM_CH(NUM_CH), .SMP_W(SMP_W)) u_hit (
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .thresh    (thresh),
        .trig_in_lo(trig_in_lo),
        .trig_in_hi(trig_in_hi),
        .hit       (hit),
        .gate      (gate)
    );

    // Edge hits go straight out to the neighboring sections.
    assign trig_out_lo = hit[0];
    assign trig_out_hi = hit[NUM_CH-1];

    // Fill tracker: counts strobes until the delay lines hold real data.
    always_ff @(posedge clk) begin
        if (!rst_n)                    fill_cnt <= '0;
        else if (smp_valid && !filled) fill_cnt <= fill_cnt + 1'b1;
    end
    assign filled = (fill_cnt == FILL_W'(PRE));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        zs_chan_window #(.SMP_W(SMP_W), .PRE(PRE), .POST(POST)) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_valid(smp_valid),
            .filled   (filled),
            .gate     (gate[ch]),
            .smp_in   (smp_data[ch*SMP_W +: SMP_W]),
            .wr_en_o  (wr_en[ch]),
            .wr_data_o(wr_data[ch*SMP_W +: SMP_W])
        );
    end

    // R6: write pulses only follow a strobe.
    p_pulse_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> (wr_en == '0));

    // R8: reset deasserts every write enable.
    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> (wr_en == '0));

    // R8: strobes before the delay lines fill store nothing.
    p_no_early_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !filled) |=> (wr_en == '0));
endmodule

// File: tb/zs_neighbor_gate_tb.sv
// Bench for zs_neighbor_gate. A behavioural model keeps the full history
// of strobes since reset and recomputes each enable from it. The result
// is compared with the design on every clock.
module zs_neighbor_gate_tb_top;
    localparam int NCH  = 8;
    localparam int W    = 12;
    localparam int PRE  = 2;
    localparam int POST = 2;
    localparam int MAXS = 1024;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              smp_valid;
    logic [NCH*W-1:0]  smp_data;
    logic [W-1:0]      thresh;
    logic              trig_in_lo, trig_in_hi;
    logic              trig_out_lo, trig_out_hi;
    logic [NCH-1:0]    wr_en;
    logic [NCH*W-1:0]  wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R8";

    logic [W-1:0]   drv_s [NCH];
    logic [NCH-1:0] gate_h [MAXS];
    logic [W-1:0]   smp_h  [MAXS][NCH];
    int             nstr;
    logic [NCH-1:0] exp_en;
    logic [W-1:0]   exp_data [NCH];

    always #5 clk = ~clk;

    zs_neighbor_gate #(.NUM_CH(NCH), .SMP_W(W), .PRE(PRE), .POST(POST)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .thresh(thresh), .trig_in_lo(trig_in_lo), .trig_in_hi(trig_in_hi),
        .trig_out_lo(trig_out_lo), .trig_out_hi(trig_out_hi),
        .wr_en(wr_en), .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    // Compare the registered outputs with the model's prediction.
    task automatic compare();
        check(wr_en === exp_en, "wr_en", int'(wr_en), int'(exp_en));
        for (int c = 0; c < NCH; c++)
            if (exp_en[c])
                check(wr_data[c*W +: W] === exp_data[c], $sformatf("wr_data ch%0d", c),
                      int'(wr_data[c*W +: W]), int'(exp_data[c]));
    endtask

    // One clock: compare, drive, check edge triggers, update the model.
    task automatic tick(input bit v, input bit tl, input bit th);
        logic [NCH+1:0] ext;
        logic [NCH-1:0] g;
        @(negedge clk);
        compare();
        smp_valid  = v;
        trig_in_lo = tl;
        trig_in_hi = th;
        for (int c = 0; c < NCH; c++) smp_data[c*W +: W] = drv_s[c];
        #1;
        // R4: edge outputs follow own edge hits only
        check(trig_out_lo === (v && drv_s[0] >= thresh), "trig_out_lo R4",
              int'(trig_out_lo), int'(v && drv_s[0] >= thresh));
        check(trig_out_hi === (v && drv_s[NCH-1] >= thresh), "trig_out_hi R4",
              int'(trig_out_hi), int'(v && drv_s[NCH-1] >= thresh));
        exp_en = '0;
        if (v) begin
            ext[0] = tl;
            ext[NCH+1] = th;
            for (int c = 0; c < NCH; c++) ext[c+1] = (drv_s[c] >= thresh);
            for (int c = 0; c < NCH; c++) g[c] = ext[c] | ext[c+1] | ext[c+2];
            gate_h[nstr] = g;
            for (int c = 0; c < NCH; c++) smp_h[nstr][c] = drv_s[c];
            if (nstr - PRE >= 0) begin
                for (int c = 0; c < NCH; c++) begin
                    int lo;
                    lo = nstr - PRE - POST;
                    if (lo < 0) lo = 0;
                    for (int j = lo; j <= nstr; j++)
                        if (gate_h[j][c]) exp_en[c] = 1'b1;
                    exp_data[c] = smp_h[nstr-PRE][c];
                end
            end
            nstr++;
        end
    endtask

    task automatic quiet();
        for (int c = 0; c < NCH; c++) drv_s[c] = W'(100 + c);
    endtask

    // Strobe followed by idle cycles.
    task automatic strobe(input int gap, input bit tl = 1'b0, input bit th = 1'b0);
        tick(1'b1, tl, th);
        for (int i = 0; i < gap; i++) tick(1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        smp_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R8";
        check(wr_en === '0, "wr_en in reset R8", int'(wr_en), 0);
        rst_n = 1'b1;
        nstr = 0;
        exp_en = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0;
        trig_in_lo = 1'b0; trig_in_hi = 1'b0; thresh = 12'd2000;
        nstr = 0; exp_en = '0;
        for (int c = 0; c < NCH; c++) exp_data[c] = '0;
        quiet();
        do_reset();

        // R8: hit on the very first strobe after reset
        cur_req = "R8";
        drv_s[4] = 12'd3000;
        strobe(0);
        quiet();
        repeat (6) strobe(0);

        // R9 and R6: isolated hit with idle gaps between strobes
        cur_req = "R9";
        drv_s[3] = 12'd2500;
        strobe(3);
        quiet();
        repeat (6) strobe(2);

        // R1: exactly at threshold, then one below
        cur_req = "R1";
        drv_s[5] = 12'd2000;
        strobe(1);
        quiet();
        repeat (5) strobe(0);
        drv_s[1] = 12'd1999;
        strobe(1);
        quiet();
        repeat (5) strobe(0);

        // R4 and R2: edge channel hits
        cur_req = "R4";
        drv_s[0] = 12'd4095;
        strobe(0, 1'b1, 1'b0);
        quiet();
        drv_s[7] = 12'd2222;
        strobe(0, 1'b0, 1'b1);
        quiet();
        repeat (5) strobe(0);

        // R3: external triggers alone
        cur_req = "R3";
        strobe(0, 1'b1, 1'b0);
        repeat (5) strobe(0);
        strobe(1, 1'b0, 1'b1);
        repeat (5) strobe(0);

        // R7: repeated gates keep one window open
        cur_req = "R7";
        for (int k = 0; k < 4; k++) begin
            drv_s[5] = 12'd3333;
            strobe(0);
            quiet();
            repeat (3) strobe(0);
        end
        repeat (5) strobe(0);

        // R5 and R2: random samples with occasional hits and gaps
        cur_req = "R5";
        for (int n = 0; n < 300; n++) begin
            for (int c = 0; c < NCH; c++)
                drv_s[c] = (($urandom % 20) == 0) ? W'(1800 + ($urandom % 2296))
                                                  : W'($urandom % 1500);
            strobe($urandom % 3, ($urandom % 25) == 0, ($urandom % 25) == 0);
        end

        // R8: reset in the middle of an open window
        quiet();
        drv_s[2] = 12'd3900;
        strobe(0);
        quiet();
        do_reset();
        cur_req = "R8";
        repeat (6) strobe(0);
        @(negedge clk);
        compare();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule